// File: doc/BRIEF.md
# Saturating Seconds Counter with Start/Stop and Win Flag

This block is the timing core of a small stopwatch. A prescaler divides the system clock into a one-cycle tick once per second. A run flag passes that tick on to a two-digit decimal counter. One pushbutton toggles the run flag: each press starts or stops counting. A second pushbutton clears everything back to zero.

The counter starts at 00 and climbs one step per tick. When it reaches its limit (twenty by default) it holds there and raises a win flag, which a display stage uses to start a celebration pattern. The count leaves the limit only when the clear button is pressed or the system is reset.

The outputs are the tens and ones digits as separate BCD fields, plus the win flag. All of them are registered. Both buttons are synchronised into the clock domain. The start/stop button is edge-detected, so a press that is held for many cycles gives one toggle. Every register runs on the one system clock, and the tick is only an enable.

Top module: `secs_tally`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the next outputs are tens 0, ones 0 and win 0, and the counter is stopped.
- R2: The prescaler produces one tick every `TICK_DIV` clock cycles. It counts from the last reset or clear, and the first tick comes on the `TICK_DIV`-th edge after that. Each tick taken while running raises the count by exactly one.
- R3: Each 0-to-1 transition of `btn_go`, seen after two synchronizer flops, flips the run flag once. Holding the button high gives no further toggles.
- R4: The ones field stays within 0..9. A step from ones 9 sets ones to 0 and raises tens by one, in the same cycle.
- R5: The count never exceeds `LIMIT`. Once it is there, further ticks leave it unchanged.
- R6: `win` rises in the same cycle that the count becomes `LIMIT`. It stays high until a reset or a clear.
- R7: While `win` is high, presses of `btn_go` have no effect: the count stays at `LIMIT` and `win` stays high.
- R8: A high level on `btn_clr`, after two synchronizer flops, clears the count to 00, clears `win`, stops the counter and restarts the prescaler. This holds for as long as the level lasts.
- R9: While the counter is stopped, ticks do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_go | input | 1 | Raw start/stop button, active high |
| btn_clr | input | 1 | Raw clear button, active high |
| tens_bcd | output | 4 | Tens digit of the count, BCD |
| ones_bcd | output | 4 | Ones digit of the count, BCD |
| win | output | 1 | High while the count is at its limit |

## Verification
The assertions check on every cycle:
- the ones digit stays a valid BCD value;
- the count stays at or below the limit;
- the count only moves up by one or drops to zero;
- `win` agrees with the count being at the limit;
- `win` holds until a clear.

Only the bench's scenarios can show the behaviours that depend on timing:
- the prescaler period;
- the single toggle from a held button;
- stopping and restarting;
- presses being ignored after the win.

A behavioural reference model checks these against the design on every clock.

// File: rtl/secs_tally_pkg.sv
package secs_tally_pkg;
  localparam int BCD_W = 4;

  typedef struct packed {
    logic [BCD_W-1:0] tens;
    logic [BCD_W-1:0] ones;
  } bcd2_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level,
  output logic rise
);
  localparam int LEN = STAGES + (EDGE ? 1 : 0);

  logic [LEN-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[LEN-2:0], raw};
  end

  assign level = sh[STAGES-1];

  generate
    if (EDGE) begin : g_edge
      assign rise = sh[STAGES-1] & ~sh[STAGES];
    end else begin : g_noedge
      assign rise = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic clk,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (clr)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bcd_sat_counter.sv
module bcd_sat_counter
  import secs_tally_pkg::*;
#(
  parameter int LIMIT = 20
) (
  input  logic  clk,
  input  logic  clr,
  input  logic  step,
  output bcd2_t value,
  output logic  done
);
  localparam logic [BCD_W-1:0] PRE_T = BCD_W'((LIMIT - 1) / 10);
  localparam logic [BCD_W-1:0] PRE_O = BCD_W'((LIMIT - 1) % 10);

  logic at_pre;
  assign at_pre = (value.tens == PRE_T) && (value.ones == PRE_O);

  always_ff @(posedge clk) begin
    if (clr) begin
      value <= '0;
      done  <= 1'b0;
    end else if (step && !done) begin
      if (value.ones == BCD_W'(9)) begin
        value.ones <= '0;
        value.tens <= value.tens + 1'b1;
      end else begin
        value.ones <= value.ones + 1'b1;
      end
      if (at_pre) done <= 1'b1;
    end
  end
endmodule

// File: rtl/secs_tally.sv
module secs_tally
  import secs_tally_pkg::*;
#(
  parameter int TICK_DIV    = 50_000_000,
  parameter int LIMIT       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_go,
  input  logic             btn_clr,
  output logic [BCD_W-1:0] tens_bcd,
  output logic [BCD_W-1:0] ones_bcd,
  output logic             win
);
  logic  go_rise, go_lvl_unused;
  logic  clr_lvl, clr_rise_unused;
  logic  clear_all, tick, run;
  bcd2_t value;

  btn_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) go_sync_i (
    .clk(clk), .rst(rst), .raw(btn_go), .level(go_lvl_unused), .rise(go_rise)
  );

  btn_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) clr_sync_i (
    .clk(clk), .rst(rst), .raw(btn_clr), .level(clr_lvl), .rise(clr_rise_unused)
  );

  assign clear_all = rst | clr_lvl;

  tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .clr(clear_all), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (clear_all)            run <= 1'b0;
    else if (go_rise && !win) run <= ~run;
  end

  bcd_sat_counter #(.LIMIT(LIMIT)) cnt_i (
    .clk(clk), .clr(clear_all), .step(tick & run), .value(value), .done(win)
  );

  assign tens_bcd = value.tens;
  assign ones_bcd = value.ones;
endmodule

// File: rtl/secs_tally_chk.sv
module secs_tally_chk #(
  parameter int LIMIT = 20
) (
  input logic       clk,
  input logic       rst,
  input logic       clr_lvl,
  input logic [3:0] tens,
  input logic [3:0] ones,
  input logic       win
);
  logic [7:0] val;
  assign val = 8'(tens) * 8'd10 + 8'(ones);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (val == 8'd0 && !win)); // R1
  AST_ONES_BCD: assert property (@(posedge clk) disable iff (rst) ones <= 4'd9); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) val <= 8'(LIMIT)); // R5
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (val != $past(val)) |-> (val == $past(val) + 8'd1 || val == 8'd0)); // R2
  AST_WIN_AT_LIMIT: assert property (@(posedge clk) disable iff (rst) win == (val == 8'(LIMIT))); // R6
  AST_WIN_HOLDS: assert property (@(posedge clk) disable iff (rst) (win && !clr_lvl) |=> win); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst) clr_lvl |=> (val == 8'd0)); // R8
endmodule

bind secs_tally secs_tally_chk #(.LIMIT(LIMIT)) chk_i (
  .clk(clk), .rst(rst), .clr_lvl(clr_lvl),
  .tens(tens_bcd), .ones(ones_bcd), .win(win)
);

// File: tb/secs_tally_tb_top.sv
module secs_tally_tb_top;
  localparam int DIV = 4;
  localparam int LIM = 20;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_go = 1'b0;
  logic btn_clr = 1'b0;
  logic [3:0] tens_bcd, ones_bcd;
  logic win;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1";

  // behavioural reference state
  bit m_valid = 0;
  int m_cnt = 0, m_pre = 0;
  bit m_run = 0, m_win = 0;
  bit g1 = 0, g2 = 0, g3 = 0, c1 = 0, c2 = 0;

  always #4 clk = ~clk;

  secs_tally #(.TICK_DIV(DIV), .LIMIT(LIM), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .btn_go(btn_go), .btn_clr(btn_clr),
    .tens_bcd(tens_bcd), .ones_bcd(ones_bcd), .win(win)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // model step, compare and watchdog on each falling edge
  always @(negedge clk) begin
    bit rise, tk;
    cycles++;
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_run = 0; m_win = 0;
      g1 = 0; g2 = 0; g3 = 0; c1 = 0; c2 = 0;
      m_valid = 1;
    end else begin
      rise = g2 & ~g3;
      if (c2) begin
        m_pre = 0; m_run = 0; m_cnt = 0; m_win = 0;
      end else begin
        tk = (m_pre == DIV - 1);
        m_pre = tk ? 0 : m_pre + 1;
        if (tk && m_run && m_cnt < LIM) begin
          m_cnt++;
          if (m_cnt == LIM) m_win = 1;
        end
        if (rise && !m_win) m_run = !m_run;
      end
      g3 = g2; g2 = g1; g1 = btn_go;
      c2 = c1; c1 = btn_clr;
    end
    if (m_valid) begin
      check(phase, "tens", int'(tens_bcd), m_cnt / 10);
      check(phase, "ones", int'(ones_bcd), m_cnt % 10);
      check(phase, "win", int'(win), int'(m_win));
    end
    if (cycles > WD_LIMIT) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired: actual %0d expected <%0d cycles", cycles, WD_LIMIT);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic press_go(input int hold);
    btn_go = 1'b1; wait_cyc(hold);
    btn_go = 1'b0; wait_cyc(3);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    check("R1", "tens after reset", int'(tens_bcd), 0);
    check("R1", "win after reset", int'(win), 0);

    phase = "R9"; wait_cyc(12);
    check("R9", "idle count", int'(ones_bcd), 0);

    phase = "R3"; press_go(6);
    phase = "R2"; wait_cyc(4 * DIV);
    phase = "R9"; press_go(1); wait_cyc(3 * DIV);
    phase = "R3"; press_go(2);
    phase = "R4"; wait_cyc(12 * DIV);
    check("R4", "tens past nine", int'(tens_bcd), 1);

    phase = "R8"; btn_clr = 1'b1; wait_cyc(1); btn_clr = 1'b0; wait_cyc(4);
    check("R8", "ones after clear", int'(ones_bcd), 0);
    check("R8", "tens after clear", int'(tens_bcd), 0);
    wait_cyc(3 * DIV);
    check("R8", "stopped after clear", int'(ones_bcd), 0);

    phase = "R5"; press_go(1); wait_cyc(25 * DIV);
    check("R5", "tens saturated", int'(tens_bcd), 2);
    check("R5", "ones saturated", int'(ones_bcd), 0);
    check("R6", "win at limit", int'(win), 1);

    phase = "R7"; press_go(1); wait_cyc(2 * DIV); press_go(3); wait_cyc(2 * DIV);
    check("R7", "count held", int'(tens_bcd) * 10 + int'(ones_bcd), LIM);
    check("R7", "win held", int'(win), 1);

    phase = "R8"; btn_clr = 1'b1; wait_cyc(5); btn_clr = 1'b0; wait_cyc(3);
    check("R8", "win cleared", int'(win), 0);
    check("R8", "count cleared", int'(tens_bcd) * 10 + int'(ones_bcd), 0);

    phase = "R1"; press_go(1); wait_cyc(3 * DIV); rst = 1'b1; wait_cyc(1); rst = 1'b0;
    check("R1", "reset mid-run", int'(ones_bcd), 0);
    wait_cyc(3 * DIV);
    check("R1", "stopped after reset", int'(ones_bcd), 0);

    finish_run();
  end
endmodule